// File: doc/BRIEF.md
# Trained Multi-Lane Skew Remover

This block sits behind the samplers of a parallel link that carries several serial lanes, all sampled once per cycle of one common clock. Every lane is idle at 0 when training starts, then carries the same training word, repeated and sent most significant bit first. Skew between the lanes makes the first 0-to-1 change reach each lane at a different cycle. When training starts, the block counts the cycles to that change on every lane. It then sets a per-lane delay so that each early lane is held back to match the latest lane.

Each lane's delay is a tapped shift register whose output comes from a multiplexer. After the taps are set and the tap lines have had time to fill, the block looks for the word boundary. It locks when it has seen a fixed number of training words in a row on all lanes at the same bit position. From then on it outputs one parallel word per lane for every word period. A lane that never changes within a set timeout makes the block stop in an error state. So does a skew spread larger than the tap line can absorb.

Top module: `lane_deskew_trainer`

## Requirements
- R1: After reset, `locked`, `skew_err` and `word_valid` are all low.
- R2: The block stays idle, and neither locks nor flags an error, until `train_go` is high, whatever the lanes carry.
- R3: Each lane's added delay is the latest lane's first-change count minus its own. For skews whose spread is at most TAPS-1 cycles, the words sent on lane l after training (most significant bit first) appear in `data_out` bits [l*WORD_W +: WORD_W], and all lanes' words appear in the same output word.
- R4: If the spread between the earliest and the latest lane's first change exceeds TAPS-1 cycles, `skew_err` rises and `locked` never rises.
- R5: If some lane shows no change within `timeout_cycles` cycles of the start of measurement, `skew_err` rises and `locked` never rises.
- R6: Lock needs MATCHES (default 4) consecutive training words on all lanes at one word boundary. A training sequence too short to give them leaves the block unlocked and without error.
- R7: `word_valid` is high only while `locked`, and while locked it pulses exactly once every WORD_W cycles.
- R8: One cycle after `retrain`, `locked`, `skew_err` and `word_valid` are low and all tap selections are zero.
- R9: Tap selections do not change while locked, so aligned payload stays correct for as long as the block is locked.
- R10: `locked` and `skew_err` are never high together, and `skew_err` stays high until `retrain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock shared by all lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| retrain | input | 1 | Return to idle and clear the tap selections |
| train_go | input | 1 | Leaves idle and starts skew measurement |
| timeout_cycles | input | TO_W | Cycles allowed for every lane to show its first change |
| lane_in | input | LANES | One sampled bit per lane per cycle |
| data_out | output | LANES*WORD_W | Aligned words, lane l in bits [l*WORD_W +: WORD_W] |
| word_valid | output | 1 | `data_out` holds a complete word |
| locked | output | 1 | Skew removed and word boundary found |
| skew_err | output | 1 | Skew spread too large or a lane timed out |

## Verification
The bound checker watches the status outputs on every cycle. It checks that lock and error never coincide and that the error is sticky. It also checks that valid words appear only under lock and never on back-to-back cycles, that retrain clears everything in one cycle, and that the tap selections stay frozen while locked. Only the bench's scenarios can show that the delays are right. It sweeps many skew combinations up to the full tap range and confirms that every lane's payload comes out in the same word. The same scenarios show that lock needs enough training words and that a stuck lane or a spread one cycle too wide ends in an error.

// File: rtl/lane_deskew_trainer.sv
module lane_deskew_trainer #(
  parameter int LANES = 4,
  parameter int TAPS = 16,
  parameter int WORD_W = 8,
  parameter int MATCHES = 4,
  parameter int TO_W = 12,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 8'hB1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    retrain,
  input  logic                    train_go,
  input  logic [TO_W-1:0]         timeout_cycles,
  input  logic [LANES-1:0]        lane_in,
  output logic [LANES*WORD_W-1:0] data_out,
  output logic                    word_valid,
  output logic                    locked,
  output logic                    skew_err
);
  localparam int TSW = $clog2(TAPS);
  localparam int BW = $clog2(WORD_W);
  localparam int MW = $clog2(MATCHES + 1);

  typedef enum logic [2:0] {S_IDLE, S_MEASURE, S_PROGRAM, S_SEARCH, S_LOCKED, S_FAULT} st_t;
  st_t state;

  logic [LANES-1:0] lane_q, lane_qq, seen, edge_now, aligned;
  logic all_seen;
  logic [TO_W-1:0] cnt, lmax, lmin, spread;
  logic [LANES-1:0][TO_W-1:0] arr;
  logic [LANES-1:0][TSW-1:0] sel;
  logic [LANES-1:0][TAPS-2:0] sr;
  logic [LANES-1:0][WORD_W-1:0] win;
  logic [BW-1:0] bcnt;
  logic [MW-1:0] mcnt;
  logic match;

  assign edge_now = lane_q ^ lane_qq;
  assign locked = (state == S_LOCKED);
  assign skew_err = (state == S_FAULT);
  assign word_valid = locked && (bcnt == BW'(WORD_W - 1));
  assign spread = lmax - lmin;

  always_comb begin
    lmax = '0;
    lmin = '1;
    match = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (arr[l] > lmax) lmax = arr[l];
      if (arr[l] < lmin) lmin = arr[l];
      if (win[l] != TRAIN_WORD) match = 1'b0;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TAPS-1:0] line;
    assign line = {sr[l], lane_q[l]};
    assign aligned[l] = line[sel[l]];
    assign data_out[l*WORD_W +: WORD_W] = win[l];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sr[l] <= '0;
        win[l] <= '0;
      end else begin
        sr[l] <= {sr[l][TAPS-3:0], lane_q[l]};
        win[l] <= {win[l][WORD_W-2:0], aligned[l]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      lane_qq <= '0;
    end else begin
      lane_q <= lane_in;
      lane_qq <= lane_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || retrain) begin
      state <= S_IDLE;
      cnt <= '0;
      seen <= '0;
      all_seen <= 1'b0;
      arr <= '0;
      sel <= '0;
      bcnt <= '0;
      mcnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (train_go) begin
          state <= S_MEASURE;
          cnt <= '0;
          seen <= '0;
          all_seen <= 1'b0;
          arr <= '0;
        end
        S_MEASURE: begin
          cnt <= cnt + 1'b1;
          for (int l = 0; l < LANES; l++)
            if (!seen[l] && edge_now[l]) begin
              seen[l] <= 1'b1;
              arr[l] <= cnt;
            end
          all_seen <= &(seen | edge_now);
          if (all_seen) begin
            cnt <= '0;
            if (spread > TO_W'(TAPS - 1)) state <= S_FAULT;
            else begin
              state <= S_PROGRAM;
              for (int l = 0; l < LANES; l++) sel[l] <= TSW'(lmax - arr[l]);
            end
          end else if (cnt == timeout_cycles) state <= S_FAULT;
        end
        S_PROGRAM: begin
          cnt <= cnt + 1'b1;
          if (cnt == TO_W'(TAPS - 1)) begin
            state <= S_SEARCH;
            mcnt <= '0;
            bcnt <= '0;
          end
        end
        S_SEARCH: begin
          if (mcnt == '0) begin
            if (match) begin
              mcnt <= MW'(1);
              bcnt <= '0;
            end
          end else if (bcnt == BW'(WORD_W - 1)) begin
            bcnt <= '0;
            if (!match) mcnt <= '0;
            else if (mcnt == MW'(MATCHES - 1)) state <= S_LOCKED;
            else mcnt <= mcnt + 1'b1;
          end else bcnt <= bcnt + 1'b1;
        end
        S_LOCKED: bcnt <= (bcnt == BW'(WORD_W - 1)) ? '0 : bcnt + 1'b1;
        default: state <= S_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/lane_deskew_trainer_chk.sv
module lane_deskew_trainer_chk #(
  parameter int LANES = 4,
  parameter int TAPS = 16,
  parameter int WORD_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic retrain,
  input logic locked,
  input logic skew_err,
  input logic word_valid,
  input logic [LANES-1:0][$clog2(TAPS)-1:0] sel
);
  // R10
  lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(locked && skew_err));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (skew_err && !retrain) |=> skew_err);
  // R7
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> locked);
  // R7
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && !retrain) |=> !word_valid);
  // R8
  retrain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (!locked && !skew_err && !word_valid && sel == '0));
  // R9
  taps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !retrain) |=> (!locked || $stable(sel)));
endmodule

bind lane_deskew_trainer lane_deskew_trainer_chk #(.LANES(LANES), .TAPS(TAPS), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/lane_deskew_trainer_test.sv
module lane_deskew_trainer_test;
  localparam int L = 4, W = 8, PRE = 4, NPAY = 10;
  localparam logic [7:0] TW = 8'hB1;

  logic clk = 0, rst_n = 0, retrain = 0, train_go = 0;
  logic [11:0] timeout_cycles = 12'd60;
  logic [L-1:0] lane_in = '0;
  logic [L*W-1:0] data_out;
  logic word_valid, locked, skew_err;

  int checks = 0, errors = 0, cyc = 0;
  int skew[L];
  int ntrain, stuck;

  lane_deskew_trainer uut (.clk, .rst_n, .retrain, .train_go, .timeout_cycles,
    .lane_in, .data_out, .word_valid, .locked, .skew_err);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pay(int l, int j);
    logic [7:0] v = 8'(j * 37 + l * 91 + 5);
    if (v == TW) v = 8'h4E;
    return v;
  endfunction

  function automatic logic bit_at(int l, int t);
    int u = t - skew[l];
    logic [7:0] w;
    if (l == stuck || u < PRE) return 1'b0;
    u -= PRE;
    if (u / 8 < ntrain) return TW[7 - u % 8];
    if (u / 8 - ntrain < NPAY) begin
      w = pay(l, u / 8 - ntrain);
      return w[7 - u % 8];
    end
    return 1'b0;
  endfunction

  // expect: 0 lock, 1 error, 2 neither
  task automatic run_case(input int s0, s1, s2, s3, k, stk, go, expect_res, input string req);
    bit got_lock = 0, got_err = 0, in_pay = 0, pay_ok = 1;
    int j = 0, last_v = -1;
    int limit = PRE + 20 + (k + NPAY) * 8 + 40;
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    ntrain = k; stuck = stk;
    @(negedge clk); retrain = 1; train_go = 0; lane_in = '0;
    @(negedge clk); retrain = 0;
    chk(!locked && !skew_err && !word_valid, "R8 retrain clear", {locked, skew_err, word_valid}, 0);
    @(negedge clk);
    train_go = go[0];
    for (int t = 0; t < limit; t++) begin
      for (int l = 0; l < L; l++) lane_in[l] = bit_at(l, t);
      @(negedge clk);
      if (word_valid && !locked) chk(0, "R7 valid without lock", 1, 0);
      if (locked && skew_err) chk(0, "R10 lock and error", 1, 0);
      if (got_err && !skew_err) chk(0, "R10 error not sticky", 0, 1);
      got_lock |= locked;
      got_err |= skew_err;
      if (word_valid) begin
        if (last_v >= 0 && t - last_v != W) chk(0, "R7 valid spacing", t - last_v, W);
        last_v = t;
        if (!in_pay && data_out != {L{TW}}) in_pay = 1;
        if (in_pay && j < NPAY) begin
          logic [L*W-1:0] e;
          for (int l = 0; l < L; l++) e[l*W +: W] = pay(l, j);
          chk(data_out == e, "R3 aligned word", int'(data_out), int'(e));
          if (data_out != e) pay_ok = 0;
          j++;
        end
      end
    end
    train_go = 0;
    if (expect_res == 0) begin
      chk(got_lock && !got_err, {req, " lock reached"}, {got_lock, got_err}, 2);
      chk(j == NPAY && pay_ok, "R9 payload stays aligned under lock", j, NPAY);
    end else if (expect_res == 1) begin
      chk(got_err && !got_lock, {req, " error raised"}, {got_lock, got_err}, 1);
    end else begin
      chk(!got_err && !got_lock, {req, " no lock no error"}, {got_lock, got_err}, 0);
    end
  endtask

  initial begin
    stuck = -1; ntrain = 14;
    for (int l = 0; l < L; l++) skew[l] = 0;
    repeat (3) @(negedge clk);
    chk(!locked && !skew_err && !word_valid, "R1 reset state", {locked, skew_err, word_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!locked && !skew_err && !word_valid, "R1 after reset release", {locked, skew_err, word_valid}, 0);
    // R2: full training traffic without train_go
    run_case(0, 3, 5, 1, 14, -1, 0, 2, "R2");
    // R3 sweep of skew combinations within the tap range
    for (int a = 0; a < 16; a++)
      run_case(a, (a * 5 + 3) % 16, 15 - a, (a * 11) % 16, 14, -1, 1, 0, "R3");
    run_case(0, 0, 0, 0, 14, -1, 1, 0, "R3 zero skew");
    run_case(0, 15, 15, 0, 14, -1, 1, 0, "R3 full spread");
    // R4 spread one past the limit
    run_case(0, 16, 2, 2, 14, -1, 1, 1, "R4");
    run_case(30, 14, 14, 14, 14, -1, 1, 1, "R4");
    // R5 stuck lane
    run_case(0, 2, 4, 6, 14, 2, 1, 1, "R5");
    // R6 too few training words
    run_case(0, 0, 0, 0, 3, -1, 1, 2, "R6");
    run_case(2, 9, 0, 4, 14, -1, 1, 0, "R6 relock after short training");
    @(negedge clk); retrain = 1;
    @(negedge clk); retrain = 0;
    chk(!locked && !skew_err, "R8 final retrain", {locked, skew_err}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule